// File: doc/BRIEF.md
# Redundant Node Mastership Arbiter

This block runs once per node in a three-node redundant ensemble. Every node publishes a two-bit operating mode on a shared mode bus and watches the modes of the other two. From those modes, a master-capable strap and a start-selection pulse, the arbiter decides whether its node serves as a checker or takes the master role. It resolves simultaneous master claims by node priority and notices when the current master disappears.

A claim passes through a visible transient state for a fixed number of clocks before it becomes mastership. During that window every claimant can see the others, and any claimant that sees a higher-numbered rival steps back to checker. When a peer that was master drops to the all-zero (offline) code, the arbiter raises a master-lost indication in the same cycle. It then reselects, so that the highest-numbered remaining checker takes over. The cycle in which the node commits to master is marked by a single-cycle pulse, which lets the surrounding logic switch on outputs that only the master drives.

Top module: `nma_arbiter`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (offline) and both `master_lost_o` and `became_master_o` are low. Mode codes are 2'b00 offline, 2'b01 checker, 2'b10 claim (transient) and 2'b11 master. Node n's mode occupies bits [2n+1:2n] of `node_modes_i`.
- R2: A start pulse seen while no peer is online (every peer slot 2'b00) makes `mode_o` 2'b01 on the next clock.
- R3: A start pulse while a peer shows master moves an offline or checker node to checker. A start pulse while the node itself is master keeps it master.
- R4: A start pulse while no peer is master and at least one peer is online moves a master-capable node to claim. The same pulse moves a node that is not master-capable to checker.
- R5: A node in claim shows 2'b10 for exactly 2 clocks and then shows 2'b11, unless it is demoted under R6.
- R6: While in claim, a peer with a higher node index showing claim or master sends the node to checker at the next clock. Lower-index claimants have no effect.
- R7: `master_lost_o` is high, combinationally in the same cycle, when some peer slot held 2'b11 in the previous cycle and now reads 2'b00, provided the node itself is not offline. It stays low when an offline node sees this change and when a checker peer drops to 2'b00.
- R8: On master loss, a non-master node moves to claim if it is master-capable and no higher-index peer shows checker or claim. Otherwise it moves to checker.
- R9: `became_master_o` is high for exactly one cycle: the first cycle in which `mode_o` shows 2'b11.
- R10: A start pulse during claim has no effect on the claim timing. The node's own slot of `node_modes_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_capable_i | input | 1 | Strap: node may take the master role |
| node_idx_i | input | 2 | This node's index (higher index wins) |
| start_sel_i | input | 1 | Start-selection pulse |
| node_modes_i | input | 6 | Mode bus, two bits per node, own slot ignored |
| mode_o | output | 2 | This node's published mode |
| master_lost_o | output | 1 | Master-lost indication, same-cycle |
| became_master_o | output | 1 | One-cycle pulse on commit to master |

## Verification
The bench sets up a race between claimants in both directions. A design that compared priority the wrong way would demote on a lower rival or commit alongside a higher one. It checks that the claim lasts exactly two visible cycles, which catches an off-by-one timer, and it re-pulses start during a claim to expose a design that restarts the timer. On master loss it checks the same-cycle indication and the takeover rule from both a top-index and a middle-index node. It also drops a checker peer and drops a master while the node is offline, so an over-eager loss detector would fire in those cases.

// File: rtl/nma_pkg.sv
`timescale 1ns/1ps
package nma_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF = 2'b00,
    MODE_CHK = 2'b01,
    MODE_CLM = 2'b10,
    MODE_MST = 2'b11
  } mode_e;
endpackage

// File: rtl/nma_peer_view.sv
`timescale 1ns/1ps
module nma_peer_view
  import nma_pkg::*;
#(
  parameter int NODES = 3,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [NODES*MODE_W-1:0] node_modes_i,
  input  logic [IW-1:0]           own_idx_i,
  output logic                    any_master_o,
  output logic                    any_online_o,
  output logic                    higher_active_o,
  output logic                    higher_checker_o
);
  logic [NODES-1:0] mst_v, onl_v, hact_v, hchk_v;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [MODE_W-1:0] m;
    logic              peer, higher;
    assign m      = node_modes_i[n*MODE_W +: MODE_W];
    assign peer   = (own_idx_i != IW'(n));
    assign higher = (IW'(n) > own_idx_i);
    assign mst_v[n]  = peer && (m == MODE_MST);
    assign onl_v[n]  = peer && (m != MODE_OFF);
    // higher-priority rival for an open claim
    assign hact_v[n] = higher && ((m == MODE_CLM) || (m == MODE_MST));
    // higher-numbered checker outranks this node on takeover
    assign hchk_v[n] = higher && ((m == MODE_CHK) || (m == MODE_CLM));
  end

  assign any_master_o     = |mst_v;
  assign any_online_o     = |onl_v;
  assign higher_active_o  = |hact_v;
  assign higher_checker_o = |hchk_v;
endmodule

// File: rtl/nma_loss_detect.sv
`timescale 1ns/1ps
module nma_loss_detect
  import nma_pkg::*;
#(
  parameter int NODES = 3,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NODES*MODE_W-1:0] node_modes_i,
  input  logic [IW-1:0]           own_idx_i,
  output logic                    lost_o
);
  logic [NODES*MODE_W-1:0] prev_q;
  logic [NODES-1:0]        drop_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= node_modes_i;
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    assign drop_v[n] = (own_idx_i != IW'(n))
                    && (prev_q[n*MODE_W +: MODE_W] == MODE_MST)
                    && (node_modes_i[n*MODE_W +: MODE_W] == MODE_OFF);
  end

  assign lost_o = |drop_v;
endmodule

// File: rtl/nma_claim_timer.sv
`timescale 1ns/1ps
module nma_claim_timer #(
  parameter int CLAIM_CYC = 2,
  localparam int CW = $clog2(CLAIM_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = run_i && (cnt_q == CW'(CLAIM_CYC - 1));
endmodule

// File: rtl/nma_arbiter.sv
`timescale 1ns/1ps
module nma_arbiter
  import nma_pkg::*;
#(
  parameter int NODES     = 3,
  parameter int CLAIM_CYC = 2,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    master_capable_i,
  input  logic [IW-1:0]           node_idx_i,
  input  logic                    start_sel_i,
  input  logic [NODES*MODE_W-1:0] node_modes_i,
  output logic [MODE_W-1:0]       mode_o,
  output logic                    master_lost_o,
  output logic                    became_master_o
);
  mode_e mode_q, mode_d;
  logic  any_master, any_online, higher_active, higher_checker;
  logic  lost_raw, lost_evt, claim_done, bm_q;

  nma_peer_view #(.NODES(NODES)) u_view (
    .node_modes_i     (node_modes_i),
    .own_idx_i        (node_idx_i),
    .any_master_o     (any_master),
    .any_online_o     (any_online),
    .higher_active_o  (higher_active),
    .higher_checker_o (higher_checker)
  );

  nma_loss_detect #(.NODES(NODES)) u_loss (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .node_modes_i (node_modes_i),
    .own_idx_i    (node_idx_i),
    .lost_o       (lost_raw)
  );

  nma_claim_timer #(.CLAIM_CYC(CLAIM_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (mode_q == MODE_CLM),
    .done_o (claim_done)
  );

  assign lost_evt = lost_raw && (mode_q != MODE_OFF);

  always_comb begin
    mode_d = mode_q;
    if (mode_q == MODE_CLM) begin
      if (higher_active)   mode_d = MODE_CHK;
      else if (claim_done) mode_d = MODE_MST;
    end else if (lost_evt && (mode_q != MODE_MST)) begin
      mode_d = (master_capable_i && !higher_checker) ? MODE_CLM : MODE_CHK;
    end else if (start_sel_i) begin
      if (mode_q == MODE_MST)              mode_d = MODE_MST;
      else if (any_master || !any_online)  mode_d = MODE_CHK;
      else                                 mode_d = master_capable_i ? MODE_CLM : MODE_CHK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      bm_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bm_q   <= (mode_q == MODE_CLM) && (mode_d == MODE_MST);
    end
  end

  assign mode_o          = mode_q;
  assign master_lost_o   = lost_evt;
  assign became_master_o = bm_q;
endmodule

// File: rtl/nma_checker.sv
`timescale 1ns/1ps
module nma_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_sel_i,
  input logic [1:0] mode_i,
  input logic       lost_i,
  input logic       bm_i
);
  // R9: pulse coincides with master mode
  p_pulse_in_master_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_i |-> (mode_i == 2'b11));

  // R9: pulse lasts a single cycle
  p_pulse_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_i |=> !bm_i);

  // R5: master is entered only from claim
  p_master_via_claim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && $past(mode_i) != 2'b11) |-> ($past(mode_i) == 2'b10));

  // R2: leaving offline needs a start pulse
  p_offline_exit_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'b00 && mode_i != 2'b00) |-> $past(start_sel_i));

  // R7: no loss indication while offline
  p_no_loss_offline_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |-> (mode_i != 2'b00));
endmodule

bind nma_arbiter nma_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_sel_i (start_sel_i),
  .mode_i      (mode_o),
  .lost_i      (master_lost_o),
  .bm_i        (became_master_o)
);

// File: tb/tb_nma_arbiter.sv
`timescale 1ns/1ps
module tb_nma_arbiter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cap = 1'b1;
  logic [1:0] idx = 2'd1;
  logic       start = 1'b0;
  logic [5:0] modes = '0;
  logic [1:0] mode;
  logic       lost, bm;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  nma_arbiter dut (
    .clk_i (clk), .rst_ni (rst_ni), .master_capable_i (cap),
    .node_idx_i (idx), .start_sel_i (start), .node_modes_i (modes),
    .mode_o (mode), .master_lost_o (lost), .became_master_o (bm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_node(input int n, input logic [1:0] m);
    modes[2*n +: 2] = m;
  endtask

  task automatic do_reset(input logic [1:0] i, input logic c);
    @(negedge clk);
    rst_ni = 1'b0; idx = i; cap = c; start = 1'b0; modes = '0;
    step(); step();
    rst_ni = 1'b1;
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'd1, 1'b1);
    chk("R1 reset mode", mode, 2'b00);
    chk("R1 reset lost", lost, 1'b0);
    chk("R1 reset pulse", bm, 1'b0);
  endtask

  task automatic t_alone();
    do_reset(2'd1, 1'b1);
    set_node(1, 2'b11); // own slot, must be ignored (R10)
    pulse_start();
    chk("R2 alone -> checker (R10 own slot)", mode, 2'b01);
  endtask

  task automatic t_master_exists();
    do_reset(2'd0, 1'b1);
    set_node(1, 2'b11);
    pulse_start();
    chk("R3 offline with master -> checker", mode, 2'b01);
    pulse_start();
    chk("R3 checker keeps role", mode, 2'b01);
  endtask

  task automatic t_claim();
    do_reset(2'd1, 1'b1);
    set_node(0, 2'b01);
    pulse_start();
    chk("R4 capable -> claim", mode, 2'b10);
    chk("R9 no pulse in claim", bm, 1'b0);
    step();
    chk("R5 claim second cycle", mode, 2'b10);
    step();
    chk("R5 commit to master", mode, 2'b11);
    chk("R9 pulse on commit", bm, 1'b1);
    step();
    chk("R9 pulse ends", bm, 1'b0);
    pulse_start();
    chk("R3 master keeps role", mode, 2'b11);
  endtask

  task automatic t_nocap();
    do_reset(2'd1, 1'b0);
    set_node(0, 2'b01);
    pulse_start();
    chk("R4 not capable -> checker", mode, 2'b01);
  endtask

  task automatic t_race_hi();
    do_reset(2'd1, 1'b1);
    set_node(0, 2'b01);
    pulse_start();
    set_node(2, 2'b10);
    step();
    chk("R6 higher claimant demotes", mode, 2'b01);
  endtask

  task automatic t_race_lo();
    do_reset(2'd1, 1'b1);
    set_node(0, 2'b10);
    pulse_start();
    step();
    chk("R6 lower claimant ignored", mode, 2'b10);
    step();
    chk("R6 commit despite lower claimant", mode, 2'b11);
  endtask

  task automatic t_start_in_claim();
    do_reset(2'd1, 1'b1);
    set_node(0, 2'b01);
    pulse_start();
    pulse_start();
    step();
    chk("R10 start in claim ignored", mode, 2'b11);
  endtask

  task automatic t_loss_stay();
    do_reset(2'd1, 1'b1);
    set_node(0, 2'b11); set_node(2, 2'b01);
    pulse_start();
    set_node(0, 2'b00);
    #1 chk("R7 loss same cycle", lost, 1'b1);
    step();
    chk("R8 higher checker present -> checker", mode, 2'b01);
    chk("R7 loss clears", lost, 1'b0);
  endtask

  task automatic t_loss_take();
    do_reset(2'd2, 1'b1);
    set_node(0, 2'b11); set_node(1, 2'b01);
    pulse_start();
    chk("R3 top node joins as checker", mode, 2'b01);
    set_node(0, 2'b00);
    #1 chk("R7 loss seen by top node", lost, 1'b1);
    step();
    chk("R8 highest checker claims", mode, 2'b10);
    step(); step();
    chk("R8 takeover commits", mode, 2'b11);
    chk("R9 pulse on takeover", bm, 1'b1);
  endtask

  task automatic t_loss_quiet();
    do_reset(2'd1, 1'b1);
    set_node(0, 2'b11);
    step();
    set_node(0, 2'b00);
    #1 chk("R7 no loss while offline", lost, 1'b0);
    step();
    set_node(0, 2'b11); set_node(2, 2'b01);
    pulse_start();
    set_node(2, 2'b00);
    #1 chk("R7 checker drop not a loss", lost, 1'b0);
    step();
  endtask

  initial begin
    t_reset();
    t_alone();
    t_master_exists();
    t_claim();
    t_nocap();
    t_race_hi();
    t_race_lo();
    t_start_in_claim();
    t_loss_stay();
    t_loss_take();
    t_loss_quiet();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule